// File: doc/BRIEF.md
# Interrupt Request Capture with Trigger Select

This block is the request front end of one interrupt controller. It watches a group of asynchronous interrupt request lines, brings each one into the clock domain through a short flop chain, and keeps a pending bit per line. Each line is treated either as edge-sensitive or as level-sensitive, according to a trigger-select register that software writes and reads over a byte-wide port. A compile-time write mask decides which trigger-select bits can ever be set. Lines whose bit is stuck at zero stay edge-sensitive for good.

The acknowledge logic downstream sends a per-line clear strobe when it takes an interrupt. The clear only removes the pending bit of an edge-sensitive line. A level-sensitive line stays pending for as long as its input is high. A controller initialisation pulse discards all captured requests and the edge history, but leaves the trigger selection as it was. The pending vector goes straight out to the priority and masking logic.

All pins are plain control and status signals that are sampled every clock. There is no handshake and no back-pressure. A trigger-select write takes effect in the cycle it is presented, and the pending vector is valid on every cycle.

Top module: `irqcap_top`

## Requirements
- R1: After asynchronous reset the pending vector and the trigger-select readback are both all zeros.
- R2: A trigger-select write stores the write data ANDed with the parameter WR_MASK (default 0xF8), and the readback shows it at once. Without a write the register holds its value. A bit value of 1 selects level sensitivity for that line and 0 selects edge sensitivity.
- R3: For a level-sensitive line, the pending bit equals the input as it was three clock edges earlier: two synchroniser flops plus the pending flop. It drops when the input has been low for that long.
- R4: For an edge-sensitive line, a low-to-high change of the synchronised input sets the pending bit three edges after the change. An input held high does not set the bit again after it has been cleared.
- R5: Driving an edge-sensitive input low does not clear its pending bit.
- R6: A clear strobe on an edge-sensitive line clears its pending bit at the next edge. A clear strobe on a level-sensitive line whose input is high has no effect.
- R7: If a clear strobe and a new rising edge reach the same line in the same cycle, the pending bit is set.
- R8: An initialisation pulse clears the whole pending vector and the edge history at the next edge, and leaves the trigger-select register unchanged. An edge-sensitive input that is still high is therefore captured again one edge after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | LINES | Asynchronous request lines |
| init_cmd | input | 1 | Initialisation pulse from the command decoder |
| trig_wr_en | input | 1 | Trigger-select write strobe |
| trig_wr_data | input | LINES | Trigger-select write data |
| trig_rd_data | output | LINES | Trigger-select readback |
| ack_clr | input | LINES | Per-line clear strobe from the acknowledge logic |
| pend_o | output | LINES | Pending request vector |

## Verification
A corrupted edge-history bit shows up at the line's next rising input. The pending bit is then either missing or set twice, one edge after the synchronised change. A stale pending bit is visible on pend_o in the very cycle after a clear or an initialisation pulse, so those checks sample one edge later. A wrong trigger-select value shows in the readback in the same cycle. It also shows as a level line that ignores a clear, or an edge line that obeys one, within three edges of the input change.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
  localparam int unsigned DEF_LINES = 8;
  localparam logic [7:0] WMASK_PRIMARY   = 8'hF8;
  localparam logic [7:0] WMASK_SECONDARY = 8'hDE;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irqcap_sync.sv
module irqcap_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign sync_o = chain[LAST];
endmodule

// File: rtl/irqcap_trig_reg.sv
module irqcap_trig_reg #(
  parameter int unsigned           WIDTH = 8,
  parameter logic [WIDTH-1:0]      WMASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= wr_data & WMASK;
    end
  end

  // Register only moves on a write; initialisation must not touch it (R2, R8)
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/irqcap_line.sv
module irqcap_line
  import irqcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic trig_i,
  input  logic init_i,
  input  logic clr_i,
  output logic pend_o
);
  trig_mode_e mode;
  logic       prev_q;
  logic       pend_q;
  logic       rise;

  assign mode = trig_mode_e'(trig_i);
  assign rise = level_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (init_i) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      case (mode)
        TRIG_LEVEL: pend_q <= level_i;
        default:    pend_q <= rise | (pend_q & ~clr_i);
      endcase
    end
  end

  assign pend_o = pend_q;

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !init_i) |=> (pend_q == $past(level_i)));

  assert_edge_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !init_i && pend_q && !clr_i) |=> pend_q);

  assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !init_i && clr_i && !(level_i && !prev_q)) |=> !pend_q);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !init_i && level_i && !prev_q) |=> pend_q);

  assert_init_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !pend_q);
endmodule

// File: rtl/irqcap_top.sv
module irqcap_top
  import irqcap_pkg::*;
#(
  parameter int unsigned      LINES      = DEF_LINES,
  parameter int unsigned      SYNC_DEPTH = 2,
  parameter logic [LINES-1:0] WR_MASK    = WMASK_PRIMARY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             init_cmd,
  input  logic             trig_wr_en,
  input  logic [LINES-1:0] trig_wr_data,
  output logic [LINES-1:0] trig_rd_data,
  input  logic [LINES-1:0] ack_clr,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] irq_sync;
  logic [LINES-1:0] trig_q;

  irqcap_sync #(.WIDTH(LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_in),
    .sync_o  (irq_sync)
  );

  irqcap_trig_reg #(.WIDTH(LINES), .WMASK(WR_MASK)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (trig_wr_en),
    .wr_data (trig_wr_data),
    .q       (trig_q)
  );

  generate
    for (genvar n = 0; n < LINES; n++) begin : g_line
      irqcap_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (irq_sync[n]),
        .trig_i  (trig_q[n]),
        .init_i  (init_cmd),
        .clr_i   (ack_clr[n]),
        .pend_o  (pend_o[n])
      );
    end
  endgenerate

  assign trig_rd_data = trig_q;

  // Bits outside the write mask never read back as one (R2)
  assert_mask_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_en |=> ((trig_rd_data & ~WR_MASK) == '0));
endmodule

// File: tb/irqcap_top_tb.sv
module irqcap_top_tb;
  localparam int unsigned W = 8;
  localparam time CLK_HALF = 5ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] irq_in = '0;
  logic         init_cmd = 1'b0;
  logic         trig_wr_en = 1'b0;
  logic [W-1:0] trig_wr_data = '0;
  logic [W-1:0] trig_rd_data;
  logic [W-1:0] ack_clr = '0;
  logic [W-1:0] pend_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_HALF) clk = ~clk;

  irqcap_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_in       (irq_in),
    .init_cmd     (init_cmd),
    .trig_wr_en   (trig_wr_en),
    .trig_wr_data (trig_wr_data),
    .trig_rd_data (trig_rd_data),
    .ack_clr      (ack_clr),
    .pend_o       (pend_o)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic write_trig(input logic [W-1:0] v);
    trig_wr_en   = 1'b1;
    trig_wr_data = v;
    step();
    trig_wr_en   = 1'b0;
  endtask

  task automatic t_reset();
    check(pend_o, 8'h00, "R1 pending after reset");
    check(trig_rd_data, 8'h00, "R1 trigger select after reset");
  endtask

  task automatic t_trig_mask();
    write_trig(8'hFF);
    check(trig_rd_data, 8'hF8, "R2 masked write of 0xFF");
    write_trig(8'h0C);
    check(trig_rd_data, 8'h08, "R2 masked write of 0x0C");
    step(2);
    check(trig_rd_data, 8'h08, "R2 value held without write");
  endtask

  // line 3 is level sensitive (trigger select 0x08)
  task automatic t_level();
    irq_in[3] = 1'b1;
    step(2);
    check(pend_o, 8'h00, "R3 not yet visible after two edges");
    step();
    check(pend_o, 8'h08, "R3 level line pending after three edges");
    ack_clr[3] = 1'b1;
    step();
    ack_clr[3] = 1'b0;
    check(pend_o, 8'h08, "R6 clear ignored on high level line");
    irq_in[3] = 1'b0;
    step(3);
    check(pend_o, 8'h00, "R3 level line drops with input");
  endtask

  // line 5 is edge sensitive
  task automatic t_edge();
    irq_in[5] = 1'b1;
    step(3);
    check(pend_o, 8'h20, "R4 rising edge sets pending");
    irq_in[5] = 1'b0;
    step(5);
    check(pend_o, 8'h20, "R5 low input keeps edge pending");
    ack_clr[5] = 1'b1;
    step();
    ack_clr[5] = 1'b0;
    check(pend_o, 8'h00, "R6 clear removes edge pending");
    irq_in[5] = 1'b1;
    step(3);
    check(pend_o, 8'h20, "R4 second rising edge captured");
    ack_clr[5] = 1'b1;
    step();
    ack_clr[5] = 1'b0;
    step(5);
    check(pend_o, 8'h00, "R4 held-high input does not re-set");
    irq_in[5] = 1'b0;
    step(3);
  endtask

  task automatic t_collide();
    irq_in[0] = 1'b1;
    step(2);
    ack_clr[0] = 1'b1;
    step();
    ack_clr[0] = 1'b0;
    check(pend_o, 8'h01, "R7 set wins over same-cycle clear");
    irq_in[0] = 1'b0;
    ack_clr[0] = 1'b1;
    step();
    ack_clr[0] = 1'b0;
    check(pend_o, 8'h00, "R6 later clear removes line 0");
    step(2);
  endtask

  task automatic t_init();
    irq_in[6] = 1'b1;
    irq_in[3] = 1'b1;
    step(4);
    check(pend_o, 8'h48, "R8 setup both lines pending");
    init_cmd = 1'b1;
    step();
    init_cmd = 1'b0;
    check(pend_o, 8'h00, "R8 init flushes pending");
    check(trig_rd_data, 8'h08, "R8 init keeps trigger select");
    step();
    check(pend_o, 8'h48, "R8 held edge input recaptured after init");
    irq_in = '0;
    ack_clr[6] = 1'b1;
    step();
    ack_clr[6] = 1'b0;
    step(3);
    check(pend_o, 8'h00, "R8 cleanup");
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_trig_mask();
    t_level();
    t_edge();
    t_collide();
    t_init();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule